// File: doc/BRIEF.md
# NAND Flash Device-Side Bus Front End

This block is the device side of an 8-bit multiplexed NAND flash bus. A fast system clock oversamples the asynchronous strobe and control pins. Every byte arrives on one shared byte bus. The levels of the command-latch and address-latch pins at the rising edge of the write strobe decide where the byte goes: the opcode register, the address register or the page register. Each falling edge of the read strobe drives one byte out of the page register, or a status byte, and moves the column pointer forward.

Array operations are not modelled as real cells. A page read, a page program or a block erase appears only as a busy phase of a fixed length in system-clock cycles. During that phase the ready/busy output pulls low. A program writes into the 2112-byte page register, and a later page read sees the same register, so data written can be read back. Program and erase are refused while write protect is low.

Top module: `nfb_front`

## Requirements
- R1: With chip enable (`ce_n`) low, a rising edge of `we_n` latches `io_in` as an opcode when `cle`=1 and `ale`=0. With `ce_n` high, strobes are ignored. Opcodes: 00h then 30h is page read, 80h then 10h is page program, 60h then D0h is block erase, 70h is status, FFh is reset.
- R2: Page read and page program take five address bytes: column low, column high, then row bytes 0, 1 and 2 (least significant first). Block erase takes three row bytes. At the start of a busy phase, `arr_row` shows the row of the operation.
- R3: In the data phase of a program (after the five address bytes and before 10h), a `we_n` rising edge with `cle`=`ale`=0 stores the byte at the current column and advances the column. Data bytes at any other time are dropped.
- R4: With status mode off and the block not busy, each falling edge of `re_n` puts the page byte at the current column on `io_out` and advances the column. `io_oe` is high only while `ce_n` and `re_n` are both low. `io_out` changes only on a `re_n` falling edge.
- R5: The column advances from 2111 back to 0. At a column of 2112 or above, reads return FFh and writes are dropped. Only the low 16 bits of the two column bytes are kept.
- R6: After 30h, 10h or D0h confirms a complete sequence, `rb_low` is high for exactly READ_CYC, PROG_CYC or ERASE_CYC cycles respectively.
- R7: Raising `ce_n` during a busy phase neither shortens nor stretches it.
- R8: While `wp_n` is low, 10h and D0h confirmations start no busy phase and set the fail flag. An accepted program or erase clears the flag.
- R9: A block erase reports a row whose low log2(PAGES_PER_BLOCK) bits are zero (7 bits for 128 pages per block).
- R10: After 70h, each `re_n` falling edge returns a status byte: bit 7 is the `wp_n` level, bit 6 is 1 when ready, bit 0 is the fail flag, and the other bits are 0. This also works during a busy phase. 00h leaves status mode.
- R11: Any opcode that arrives before all address bytes are in aborts the sequence. Opcodes outside the set are ignored. A confirm opcode with no matching complete sequence starts nothing.
- R12: FFh ends any busy phase at once, clears the fail flag, returns the column to 0, leaves status mode and idles the sequence.
- R13: During a busy phase every opcode except 70h and FFh is ignored, and so are all address and data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe; bytes latch on its rising edge |
| re_n | input | 1 | Read strobe; data moves on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte bus, inbound half |
| io_out | output | 8 | Byte bus, outbound half |
| io_oe | output | 1 | Drive enable for the byte bus (0 means high-impedance) |
| rb_low | output | 1 | Open-drain ready/busy: 1 pulls the line low (busy), 0 releases it |
| arr_row | output | 24 | Row address of the most recently started array operation |

## Verification
The assertions assume that all pins pass through the two-stage synchronizer, so the block sees each pin level two clocks late. They also assume the pins hold steady for several clocks around every strobe edge, that `cle` and `ale` are never high together, and that a `we_n` edge never falls in the same clock as a `re_n` edge. The bench tasks change only one strobe at a time. They hold every level for at least three clocks before and after that strobe moves, so each byte is sampled on a clean, settled bus.

// File: rtl/nfb_pkg.sv
// Shared opcodes, status-bit positions and sequence types for the
// NAND bus front end. Assumes an 8-bit byte bus.
package nfb_pkg;

    localparam logic [7:0] OP_RD_SETUP  = 8'h00;
    localparam logic [7:0] OP_RD_GO     = 8'h30;
    localparam logic [7:0] OP_PG_SETUP  = 8'h80;
    localparam logic [7:0] OP_PG_GO     = 8'h10;
    localparam logic [7:0] OP_ER_SETUP  = 8'h60;
    localparam logic [7:0] OP_ER_GO     = 8'hD0;
    localparam logic [7:0] OP_STATUS    = 8'h70;
    localparam logic [7:0] OP_RESET     = 8'hFF;

    localparam int ST_UNPROT = 7;
    localparam int ST_READY  = 6;
    localparam int ST_FAIL   = 0;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_READ  = 2'd1,
        K_PROG  = 2'd2,
        K_ERASE = 2'd3
    } op_kind_t;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_ADDR    = 2'd1,
        SQ_CONFIRM = 2'd2
    } seq_t;

endpackage

// File: rtl/nfb_pin_sync.sv
// Two-stage synchronizer for a bundle of asynchronous pins.
// Assumes the pins are stable for several clocks around each change, so
// bits of the bundle settle together. Reset loads a safe idle pattern.
module nfb_pin_sync #(
    parameter int W = 14,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1;

    // Shift pins through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= INIT;
            d_out  <= INIT;
        end else begin
            stage1 <= d_in;
            d_out  <= stage1;
        end
    end
endmodule

// File: rtl/nfb_page_buf.sv
// Page register storage: one write port and one combinational read port.
// Assumes the caller range-checks the address; contents are not reset.
module nfb_page_buf #(
    parameter int DEPTH = 2112,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    // Store one byte per accepted data strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the byte at the read column.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nfb_busy_timer.sv
// Down-counter that models an array operation as a busy interval.
// A start pulse loads the length, and busy is then high for exactly that
// many cycles. Abort clears it at once and has priority over start.
module nfb_busy_timer #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    input  logic          abort,
    output logic          busy
);
    logic [CW-1:0] remain;

    // Load, count down, or clear the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (abort)          remain <= '0;
        else if (start)          remain <= len;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/nfb_front.sv
// Device-side front end of a multiplexed 8-bit NAND flash bus.
// It oversamples the asynchronous pins, steers bytes to the opcode, address
// or page register, drives read or status bytes, and times the busy phases.
// Assumptions: the strobes are far slower than clk, cle and ale are never
// high together, and the array itself is modelled only as busy time.
module nfb_front
    import nfb_pkg::*;
#(
    parameter int PAGE_BYTES      = 2112,
    parameter int PAGES_PER_BLOCK = 128,
    parameter int COL_BYTES       = 2,
    parameter int ROW_BYTES       = 3,
    parameter int READ_CYC        = 3000,
    parameter int PROG_CYC        = 40000,
    parameter int ERASE_CYC       = 75000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce_n,
    input  logic                   cle,
    input  logic                   ale,
    input  logic                   we_n,
    input  logic                   re_n,
    input  logic                   wp_n,
    input  logic [7:0]             io_in,
    output logic [7:0]             io_out,
    output logic                   io_oe,
    output logic                   rb_low,
    output logic [8*ROW_BYTES-1:0] arr_row
);
    localparam int COL_W   = $clog2(PAGE_BYTES);
    localparam int COLR_W  = 8 * COL_BYTES;
    localparam int ROW_W   = 8 * ROW_BYTES;
    localparam int BLK_SH  = $clog2(PAGES_PER_BLOCK);
    localparam int MAX_CYC = (READ_CYC > PROG_CYC)
                           ? ((READ_CYC > ERASE_CYC) ? READ_CYC : ERASE_CYC)
                           : ((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC);
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam int PIN_W   = 14;
    localparam int IDX_W   = $clog2(COL_BYTES + ROW_BYTES + 1);
    localparam logic [ROW_W-1:0] BLK_MASK = ~((ROW_W'(1) << BLK_SH) - 1'b1);

    // Synchronized pins
    logic [PIN_W-1:0] pin_s;
    logic ce_s, cle_s, ale_s, we_s, re_s, wp_s;
    logic [7:0] byte_s;
    logic we_d, re_d, we_rise, re_fall;

    // Sequence state
    seq_t       seq;
    op_kind_t   kind;
    logic [IDX_W-1:0] addr_idx;
    logic [IDX_W-1:0] addr_need;
    logic [IDX_W-1:0] row_base;
    logic [COLR_W-1:0] col_q;
    logic [COLR_W-1:0] col_next;
    logic [ROW_W-1:0]  row_q;
    logic status_mode, fail_q;

    // Decoded events
    logic cmd_ev, adr_ev, dat_ev, rd_ev;
    logic go_read, go_prog, go_erase;
    logic tmr_start, tmr_abort, busy;
    logic [TMR_W-1:0] tmr_len;
    logic col_ok, buf_wr;
    logic [7:0] buf_rd, status_byte;

    nfb_pin_sync #(
        .W    (PIN_W),
        .INIT ({1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ce_n, cle, ale, we_n, re_n, wp_n, io_in}),
        .d_out (pin_s)
    );

    assign {ce_s, cle_s, ale_s, we_s, re_s, wp_s, byte_s} = pin_s;

    // Remember last strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_d <= 1'b1;
            re_d <= 1'b1;
        end else begin
            we_d <= we_s;
            re_d <= re_s;
        end
    end

    assign we_rise = we_s & ~we_d;
    assign re_fall = ~re_s & re_d;

    // Classify strobe events and decide which confirms launch a busy phase.
    always_comb begin
        cmd_ev   = we_rise & ~ce_s & cle_s & ~ale_s;
        adr_ev   = we_rise & ~ce_s & ale_s & ~cle_s & ~busy;
        dat_ev   = we_rise & ~ce_s & ~ale_s & ~cle_s & ~busy;
        rd_ev    = re_fall & ~ce_s;
        go_read  = cmd_ev & ~busy & (seq == SQ_CONFIRM) & (kind == K_READ)
                 & (byte_s == OP_RD_GO);
        go_prog  = cmd_ev & ~busy & (seq == SQ_CONFIRM) & (kind == K_PROG)
                 & (byte_s == OP_PG_GO);
        go_erase = cmd_ev & ~busy & (seq == SQ_CONFIRM) & (kind == K_ERASE)
                 & (byte_s == OP_ER_GO);
        tmr_start = go_read | ((go_prog | go_erase) & wp_s);
        tmr_abort = cmd_ev & (byte_s == OP_RESET);
        if (go_read)      tmr_len = TMR_W'(READ_CYC);
        else if (go_prog) tmr_len = TMR_W'(PROG_CYC);
        else              tmr_len = TMR_W'(ERASE_CYC);
    end

    // Address-cycle geometry for the pending operation.
    always_comb begin
        if (kind == K_ERASE) begin
            addr_need = IDX_W'(ROW_BYTES);
            row_base  = '0;
        end else begin
            addr_need = IDX_W'(COL_BYTES + ROW_BYTES);
            row_base  = IDX_W'(COL_BYTES);
        end
    end

    // Column bounds and the wrap from the last column back to zero.
    always_comb begin
        col_ok   = (col_q < COLR_W'(PAGE_BYTES));
        col_next = (col_q == COLR_W'(PAGE_BYTES - 1)) ? '0 : col_q + 1'b1;
        buf_wr   = dat_ev & (seq == SQ_CONFIRM) & (kind == K_PROG) & col_ok;
        status_byte            = '0;
        status_byte[ST_UNPROT] = wp_s;
        status_byte[ST_READY]  = ~busy;
        status_byte[ST_FAIL]   = fail_q;
    end

    nfb_busy_timer #(.CW(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .len   (tmr_len),
        .abort (tmr_abort),
        .busy  (busy)
    );

    nfb_page_buf #(.DEPTH(PAGE_BYTES)) u_page (
        .clk     (clk),
        .wr_en   (buf_wr),
        .wr_addr (col_q[COL_W-1:0]),
        .wr_data (byte_s),
        .rd_addr (col_q[COL_W-1:0]),
        .rd_data (buf_rd)
    );

    // Opcode sequencing, address capture, column movement and read output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq         <= SQ_IDLE;
            kind        <= K_NONE;
            addr_idx    <= '0;
            col_q       <= '0;
            row_q       <= '0;
            arr_row     <= '0;
            status_mode <= 1'b0;
            fail_q      <= 1'b0;
            io_out      <= 8'hFF;
        end else begin
            if (cmd_ev) begin
                if (byte_s == OP_RESET) begin
                    seq         <= SQ_IDLE;
                    kind        <= K_NONE;
                    addr_idx    <= '0;
                    col_q       <= '0;
                    status_mode <= 1'b0;
                    fail_q      <= 1'b0;
                end else if (byte_s == OP_STATUS) begin
                    status_mode <= 1'b1;
                    if (seq == SQ_ADDR) seq <= SQ_IDLE;
                end else if (!busy) begin
                    case (byte_s)
                        OP_RD_SETUP: begin
                            seq <= SQ_ADDR; kind <= K_READ;
                            addr_idx <= '0; status_mode <= 1'b0;
                        end
                        OP_PG_SETUP: begin
                            seq <= SQ_ADDR; kind <= K_PROG;
                            addr_idx <= '0; status_mode <= 1'b0;
                        end
                        OP_ER_SETUP: begin
                            seq <= SQ_ADDR; kind <= K_ERASE;
                            addr_idx <= '0; status_mode <= 1'b0;
                        end
                        default: begin
                            if (go_read) begin
                                seq <= SQ_IDLE; kind <= K_NONE;
                                arr_row <= row_q;
                                status_mode <= 1'b0;
                            end else if (go_prog || go_erase) begin
                                seq  <= SQ_IDLE;
                                kind <= K_NONE;
                                if (wp_s) begin
                                    fail_q  <= 1'b0;
                                    arr_row <= go_erase ? (row_q & BLK_MASK) : row_q;
                                end else begin
                                    fail_q  <= 1'b1;
                                end
                            end else if (seq == SQ_ADDR) begin
                                seq <= SQ_IDLE;
                            end
                        end
                    endcase
                end
            end

            if (adr_ev && seq == SQ_ADDR) begin
                for (int b = 0; b < COL_BYTES; b++) begin
                    if (kind != K_ERASE && addr_idx == IDX_W'(b))
                        col_q[8*b +: 8] <= byte_s;
                end
                for (int b = 0; b < ROW_BYTES; b++) begin
                    if (addr_idx == row_base + IDX_W'(b))
                        row_q[8*b +: 8] <= byte_s;
                end
                addr_idx <= addr_idx + 1'b1;
                if (addr_idx == addr_need - 1'b1) seq <= SQ_CONFIRM;
            end

            if (dat_ev && seq == SQ_CONFIRM && kind == K_PROG) begin
                col_q <= col_next;
            end

            if (rd_ev) begin
                if (status_mode) begin
                    io_out <= status_byte;
                end else if (!busy) begin
                    io_out <= col_ok ? buf_rd : 8'hFF;
                    col_q  <= col_next;
                end
            end
        end
    end

    assign io_oe  = ~ce_s & ~re_s;
    assign rb_low = busy;

endmodule

// File: rtl/nfb_checker.sv
// Property checker for nfb_front, attached by bind. It watches pins,
// outputs and a few internal decode signals. Assumes the two-stage pin
// synchronizer in front of all decode logic.
module nfb_checker #(
    parameter int MAX_BUSY = 75000,
    parameter int ROW_W    = 24,
    parameter int BLK_SH   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             io_oe,
    input logic [7:0]       io_out,
    input logic             rb_low,
    input logic             re_fall,
    input logic             wp_s,
    input logic             fail_q,
    input logic             go_read,
    input logic             go_erase,
    input logic             tmr_abort,
    input logic [ROW_W-1:0] arr_row
);
    logic [31:0] run_len;

    // Length of the current busy run, for the upper-bound check.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= '0;
        else if (rb_low) run_len <= run_len + 1'b1;
        else             run_len <= '0;
    end

    p_no_drive_deselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n, 2) |-> !io_oe);

    p_out_moves_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !re_fall |=> $stable(io_out));

    p_busy_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 32'(MAX_BUSY));

    p_protect_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_low) |-> ($past(wp_s) || $past(go_read)));

    p_fail_needs_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_q) |-> !$past(wp_s));

    p_erase_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go_erase && wp_s) |=> (arr_row[BLK_SH-1:0] == '0));

    p_reset_ends_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_abort |=> !rb_low);
endmodule

bind nfb_front nfb_checker #(
    .MAX_BUSY (MAX_CYC),
    .ROW_W    (ROW_W),
    .BLK_SH   (BLK_SH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .io_oe     (io_oe),
    .io_out    (io_out),
    .rb_low    (rb_low),
    .re_fall   (re_fall),
    .wp_s      (wp_s),
    .fail_q    (fail_q),
    .go_read   (go_read),
    .go_erase  (go_erase),
    .tmr_abort (tmr_abort),
    .arr_row   (arr_row)
);

// File: tb/sim_nfb_front.sv
// Self-checking bench for nfb_front: a vector table of program/read-back
// cases walked by one loop, then directed tests for the corner cases.
module sim_nfb_front;
    localparam int CLK_PERIOD = 10;
    localparam int RD_C = 60;
    localparam int PG_C = 120;
    localparam int ER_C = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic io_oe, rb_low;
    logic [23:0] arr_row;

    int total = 0;
    int fails = 0;
    int run = 0;
    int last_len = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nfb_front #(
        .READ_CYC  (RD_C),
        .PROG_CYC  (PG_C),
        .ERASE_CYC (ER_C)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .cle (cle), .ale (ale),
        .we_n (we_n), .re_n (re_n), .wp_n (wp_n), .io_in (io_in),
        .io_out (io_out), .io_oe (io_oe), .rb_low (rb_low), .arr_row (arr_row)
    );

    // Measure each busy run at the port.
    always @(negedge clk) begin
        if (rb_low) run = run + 1;
        else begin
            if (run != 0) last_len = run;
            run = 0;
        end
    end

    // {column[11:0], first byte, second byte, row[23:0]}
    localparam logic [51:0] TBL [6] = '{
        {12'd2111, 8'hA5, 8'h5A, 24'h000101},
        {12'd100,  8'h11, 8'hEE, 24'h012345},
        {12'd2047, 8'h77, 8'h88, 24'h00FF80},
        {12'd2048, 8'h9C, 8'h63, 24'h100000},
        {12'd1500, 8'h01, 8'h80, 24'h0000FF},
        {12'd0,    8'h3C, 8'hC3, 24'hABCDEF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk);
        cle = c; ale = a; io_in = b;
        repeat (3) @(negedge clk);
        we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);  put(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b);  put(1'b0, 1'b1, b); endtask
    task automatic dat(input logic [7:0] b);  put(1'b0, 1'b0, b); endtask

    task automatic rd(output logic [7:0] v, output logic oe);
        @(negedge clk);
        re_n = 1'b0;
        repeat (5) @(negedge clk);
        v = io_out; oe = io_oe;
        re_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic addr5(input logic [11:0] col, input logic [23:0] row);
        adr(col[7:0]); adr({4'h0, col[11:8]});
        adr(row[7:0]); adr(row[15:8]); adr(row[23:16]);
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (rb_low) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic oe;
        logic [51:0] e;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("reset rb_low", rb_low, 0);
        chk("reset io_oe", io_oe, 0);
        re_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R4 deselected no drive", io_oe, 0);
        re_n = 1'b1;
        repeat (4) @(negedge clk);
        ce_n = 1'b0;
        repeat (3) @(negedge clk);

        // Vector table: program two bytes, then read them back (R2 R3 R4 R5 R6).
        for (int i = 0; i < 6; i++) begin
            e = TBL[i];
            cmd(8'h80); addr5(e[51:40], e[23:0]);
            dat(e[39:32]); dat(e[31:24]);
            cmd(8'h10);
            wait_ready();
            chk("R6 program busy length", last_len, PG_C);
            chk("R2 program row", arr_row, e[23:0]);
            cmd(8'h00); addr5(e[51:40], e[23:0]);
            cmd(8'h30);
            wait_ready();
            chk("R6 read busy length", last_len, RD_C);
            rd(v, oe);
            chk("R3 first byte", v, e[39:32]);
            chk("R4 drive enable", oe, 1);
            rd(v, oe);
            chk("R5 second byte (wrap)", v, e[31:24]);
        end

        // R1: an opcode sent with chip enable high is ignored.
        cmd(8'hFF);
        ce_n = 1'b1; repeat (3) @(negedge clk);
        cmd(8'h70);
        ce_n = 1'b0; repeat (3) @(negedge clk);
        rd(v, oe);
        chk("R1 deselected opcode ignored", v, 8'h3C);

        // R10: status when idle and unprotected.
        cmd(8'h70);
        rd(v, oe);
        chk("R10 idle status", v, 8'hC0);

        // R8: protected erase is refused and sets fail; R12 FFh clears it.
        wp_n = 1'b0; repeat (4) @(negedge clk);
        cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'hD0);
        repeat (10) @(negedge clk);
        chk("R8 no busy when protected", rb_low, 0);
        cmd(8'h70);
        rd(v, oe);
        chk("R8 fail status", v, 8'h41);
        wp_n = 1'b1; repeat (4) @(negedge clk);
        cmd(8'hFF);
        cmd(8'h70);
        rd(v, oe);
        chk("R12 fail cleared", v, 8'hC0);

        // R11: short address sequence, then a confirm, starts nothing.
        cmd(8'h80); adr(8'h00); adr(8'h00); cmd(8'h10);
        repeat (10) @(negedge clk);
        chk("R11 aborted confirm", rb_low, 0);
        cmd(8'h80); adr(8'h00); cmd(8'h00);
        addr5(12'd0, 24'h000042); cmd(8'h30);
        wait_ready();
        chk("R11 restarted read", last_len, RD_C);

        // R5: column beyond the page reads as FFh.
        cmd(8'h00); addr5(12'd2200, 24'h0); cmd(8'h30);
        wait_ready();
        rd(v, oe);
        chk("R5 out of range read", v, 8'hFF);

        // R9 R7 R10 R13: erase with a deselect, a poll and a stray opcode.
        cmd(8'h60); adr(8'hDE); adr(8'hBC); adr(8'h0A); cmd(8'hD0);
        chk("R9 erase row aligned", arr_row, 24'h0ABC80);
        ce_n = 1'b1; repeat (20) @(negedge clk);
        ce_n = 1'b0; repeat (3) @(negedge clk);
        cmd(8'h70);
        rd(v, oe);
        chk("R10 busy status", v, 8'h80);
        cmd(8'h00);
        wait_ready();
        chk("R7 erase length with deselect", last_len, ER_C);
        rd(v, oe);
        chk("R13 opcode during busy ignored", v, 8'hC0);

        // R12: FFh cuts a program busy phase short.
        cmd(8'h80); addr5(12'd5, 24'h000007); dat(8'h12); cmd(8'h10);
        repeat (10) @(negedge clk);
        cmd(8'hFF);
        chk("R12 busy released", rb_low, 0);
        wait_ready();
        chk("R12 shortened busy", (last_len < PG_C) ? 1 : 0, 1);

        summary();
        $finish;
    end
endmodule